// File: doc/BRIEF.md
# Dual Dithered Quadrature NCO

This block produces cosine and sine samples for two independent tuning channels of a digital down-converter. Each channel keeps a 32-bit phase accumulator that advances by a programmable step on every sample strobe. A 16-bit unsigned offset rotates the phase. An optional pseudo-random term is added below the truncation point before the phase is cut down to a 12-bit table address, which spreads truncation spurs into noise. The magnitudes come from a quarter-wave table that is computed at elaboration and read through a registered port. The two outputs of a channel are 90 degrees apart.

Software sets the step, the offset and the dither enables through a small write port. The converter's mixer raises `samp_en` once for each input sample and takes the results when `out_vld` is high. Each channel has its own dither generator. The two generators start half a period apart, so their sequences do not correlate. Dither is on for both channels after reset.

Top module: `dual_dither_nco`

## Requirements
- R1: On every cycle with `samp_en` high, each channel's accumulator adds its 32-bit step word and wraps modulo 2^32, so sample k (counted from reset) has accumulated phase k·step.
- R2: While `samp_en` is low, the accumulators and the dither generators hold, and every output keeps its last value.
- R3: The 16-bit unsigned offset is added at bits 31:16 of the phase word (offset·2^16), so 0x4000 is a quarter cycle.
- R4: With dither off, the table address a is bits 31:20 of (accumulated phase + offset·2^16). The sine output is round(32767·sin(2π(a+0.5)/4096)), with halves rounded away from zero. The cosine output is that same function at address a+1024 modulo 4096.
- R5: Outputs are 16-bit two's complement in the range -32767..32767. 0x7FFF is reached at address 1024, 0x8001 at address 3072, and 0x8000 never appears.
- R6: With dither on, the low 20 bits of the channel's dither state are added to the phase before truncation, so each output pair equals the R4 pair at address a or at address a+1.
- R7: Register 4 bit 0 enables dither on channel A and bit 1 on channel B. Both bits are 1 after reset.
- R8: `out_vld` goes high exactly three clock edges after the edge that samples `samp_en` high, and it carries the outputs of that sample.
- R9: The two dither generators are maximal-length sequences over the same polynomial, started 2^22 steps apart. With equal settings, the two channels' dithered outputs differ on some samples.
- R10: Write addresses are 0 step A, 1 offset A (low 16 data bits), 2 step B, 3 offset B, 4 dither enables. A write to one channel never changes the other channel's output.
- R11: Reset clears the accumulators, the address and output registers and `out_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R10) |
| wr_data | input | 32 | Write data |
| samp_en | input | 1 | Sample strobe; advances both channels |
| out_vld | output | 1 | Outputs hold a new sample |
| a_cos | output | 16 | Channel A cosine, two's complement |
| a_sin | output | 16 | Channel A sine, two's complement |
| b_cos | output | 16 | Channel B cosine, two's complement |
| b_sin | output | 16 | Channel B sine, two's complement |

## Verification
The bench builds the block with its default parameters: a 32-bit phase, a 16-bit offset, a 12-bit address, a 16-bit output and a 23-bit dither generator. These values put every one of the four quadrant folds of the 1024-entry table within reach. The bench can reach the exact full-scale codes at the quarter-cycle and three-quarter-cycle offsets, and accumulator wrap with steps near 2^32. Because the dither is 20 bits wide, a dithered address moves by at most one step. That allows a two-candidate check against the exact model without copying the generator.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [2:0] {
    REG_FREQ_A = 3'd0,
    REG_OFS_A  = 3'd1,
    REG_FREQ_B = 3'd2,
    REG_OFS_B  = 3'd3,
    REG_DITHER = 3'd4
  } nco_reg_e;

  localparam int  NUM_CH = 2;
  localparam real TWO_PI = 6.283185307179586;
endpackage

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
  parameter int             W         = 23,
  parameter logic [W-1:0]   TAPS      = 23'h000021,
  parameter int             HALF_SEED = 0,
  parameter int             OUT_BITS  = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  output logic [OUT_BITS-1:0] dith
);
  // Galois form: one step multiplies the state by x modulo the polynomial.
  function automatic logic [W-1:0] mulx(input logic [W-1:0] s);
    return {s[W-2:0], 1'b0} ^ (s[W-1] ? TAPS : '0);
  endfunction

  function automatic logic [W-1:0] gf_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = mulx(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  // x^(2^(W-1)) is reached by W-1 squarings of x: half the period away from x^0.
  function automatic logic [W-1:0] start_state();
    logic [W-1:0] s;
    if (HALF_SEED == 0) return W'(1);
    s = W'(2);
    for (int i = 0; i < W - 1; i++) s = gf_mul(s, s);
    return s;
  endfunction

  localparam logic [W-1:0] SEED = start_state();

  logic [W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst)       st <= SEED;
    else if (step) st <= mulx(st);
  end

  assign dith = st[OUT_BITS-1:0];

  // R9: a maximal-length generator never falls into the all-zero lock-up state
  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (rst) st != '0);
endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom
  import nco_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [ADDR_W-1:0] addr_c,
  output logic [OUT_W-2:0]  mag_s,
  output logic [OUT_W-2:0]  mag_c,
  output logic              neg_s,
  output logic              neg_c
);
  localparam int  QW    = ADDR_W - 2;
  localparam int  DEPTH = 1 << QW;
  localparam int  MW    = OUT_W - 1;
  localparam real AMP   = (2.0 ** MW) - 1.0;

  logic [MW-1:0] rom [DEPTH];

  // Half-step sample positions make the quadrant folds exact mirror images.
  initial begin
    for (int k = 0; k < DEPTH; k++)
      rom[k] = MW'($rtoi(AMP * $sin(TWO_PI * (real'(k) + 0.5) / real'(DEPTH * 4)) + 0.5));
  end

  function automatic logic [QW-1:0] fold(input logic [ADDR_W-1:0] a);
    return a[QW] ? ~a[QW-1:0] : a[QW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rd_en) begin
      mag_s <= rom[fold(addr_s)];
      mag_c <= rom[fold(addr_c)];
      neg_s <= addr_s[ADDR_W-1];
      neg_c <= addr_c[ADDR_W-1];
    end
  end
endmodule

// File: rtl/nco_channel.sv
module nco_channel #(
  parameter int                PH_W      = 32,
  parameter int                OFS_W     = 16,
  parameter int                ADDR_W    = 12,
  parameter int                OUT_W     = 16,
  parameter int                LFSR_W    = 23,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 23'h000021,
  parameter int                HALF_SEED = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    samp_en,
  input  logic                    rd_en,
  input  logic                    out_en,
  input  logic [PH_W-1:0]         freq,
  input  logic [OFS_W-1:0]        ofs,
  input  logic                    dith_en,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  localparam int                TRUNC    = PH_W - ADDR_W;
  localparam logic [ADDR_W-1:0] QUARTER  = ADDR_W'(1 << (ADDR_W - 2));
  localparam logic [OUT_W-1:0]  MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [PH_W-1:0]   acc;
  logic [TRUNC-1:0]  dith;
  logic [PH_W-1:0]   dith_term;
  logic [PH_W-1:0]   ofs_sh;
  logic [ADDR_W-1:0] phase_top;
  logic [ADDR_W-1:0] ad_s_q, ad_c_q;
  logic [OUT_W-2:0]  mag_s, mag_c;
  logic              neg_s, neg_c;

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (samp_en) acc <= acc + freq;
  end

  nco_dither_lfsr #(
    .W(LFSR_W), .TAPS(LFSR_TAPS), .HALF_SEED(HALF_SEED), .OUT_BITS(TRUNC)
  ) u_dith (
    .clk(clk), .rst(rst), .step(samp_en), .dith(dith)
  );

  assign dith_term = dith_en ? PH_W'(dith) : '0;
  assign ofs_sh    = PH_W'(ofs) << (PH_W - OFS_W);
  assign phase_top = ADDR_W'((acc + ofs_sh + dith_term) >> TRUNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_s_q <= '0;
      ad_c_q <= '0;
    end else if (samp_en) begin
      ad_s_q <= phase_top;
      ad_c_q <= phase_top + QUARTER;
    end
  end

  nco_quarter_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rom (
    .clk(clk), .rd_en(rd_en), .addr_s(ad_s_q), .addr_c(ad_c_q),
    .mag_s(mag_s), .mag_c(mag_c), .neg_s(neg_s), .neg_c(neg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_o <= '0;
      cos_o <= '0;
    end else if (out_en) begin
      sin_o <= neg_s ? OUT_W'(-$signed({1'b0, mag_s})) : $signed({1'b0, mag_s});
      cos_o <= neg_c ? OUT_W'(-$signed({1'b0, mag_c})) : $signed({1'b0, mag_c});
    end
  end

  // R2: without a strobe the phase does not move
  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> $stable(acc));

  // R5: symmetric range, the most negative code is never produced
  assert_no_most_neg_R5: assert property (@(posedge clk) disable iff (rst)
    (sin_o != MOST_NEG) && (cos_o != MOST_NEG));
endmodule

// File: rtl/dual_dither_nco.sv
module dual_dither_nco
  import nco_pkg::*;
#(
  parameter int                PH_W      = 32,
  parameter int                OFS_W     = 16,
  parameter int                ADDR_W    = 12,
  parameter int                OUT_W     = 16,
  parameter int                LFSR_W    = 23,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 23'h000021
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [2:0]              wr_addr,
  input  logic [PH_W-1:0]         wr_data,
  input  logic                    samp_en,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] a_cos,
  output logic signed [OUT_W-1:0] a_sin,
  output logic signed [OUT_W-1:0] b_cos,
  output logic signed [OUT_W-1:0] b_sin
);
  localparam int PIPE = 3;

  logic [NUM_CH-1:0]       dith_en_q;
  logic [PIPE-1:0]         vld_q;
  logic signed [OUT_W-1:0] cos_w [NUM_CH];
  logic signed [OUT_W-1:0] sin_w [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[PIPE-2:0], samp_en};
  end
  assign out_vld = vld_q[PIPE-1];

  always_ff @(posedge clk) begin
    if (rst)                                dith_en_q <= '1;
    else if (wr_en && wr_addr == REG_DITHER) dith_en_q <= wr_data[NUM_CH-1:0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [2:0] FREQ_ADDR = 3'(2 * ch);
    localparam logic [2:0] OFS_ADDR  = 3'(2 * ch + 1);

    logic [PH_W-1:0]  freq_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        freq_q <= '0;
        ofs_q  <= '0;
      end else if (wr_en) begin
        if (wr_addr == FREQ_ADDR) freq_q <= wr_data;
        if (wr_addr == OFS_ADDR)  ofs_q  <= wr_data[OFS_W-1:0];
      end
    end

    nco_channel #(
      .PH_W(PH_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W),
      .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS), .HALF_SEED(ch % 2)
    ) u_ch (
      .clk(clk), .rst(rst), .samp_en(samp_en), .rd_en(vld_q[0]), .out_en(vld_q[1]),
      .freq(freq_q), .ofs(ofs_q), .dith_en(dith_en_q[ch]),
      .cos_o(cos_w[ch]), .sin_o(sin_w[ch])
    );
  end

  assign a_cos = cos_w[0];
  assign a_sin = sin_w[0];
  assign b_cos = cos_w[1];
  assign b_sin = sin_w[1];

  // R8: a strobed sample appears on the outputs three edges later
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    samp_en |-> ##3 out_vld);

  // R7: both dither enables are set when reset is released
  assert_dither_default_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> dith_en_q == '1);
endmodule

// File: tb/dual_dither_nco_bench.sv
module dual_dither_nco_bench;
  import nco_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst, wr_en, samp_en, out_vld;
  logic [2:0]         wr_addr;
  logic [31:0]        wr_data;
  logic signed [15:0] a_cos, a_sin, b_cos, b_sin;

  dual_dither_nco u_dual_dither_nco (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .samp_en(samp_en), .out_vld(out_vld),
    .a_cos(a_cos), .a_sin(a_sin), .b_cos(b_cos), .b_sin(b_sin)
  );

  // {dither on, step, offset}; channel B runs at -step and offset^0x8000
  localparam logic [48:0] VECS [8] = '{
    {1'b0, 32'h0000_0000, 16'h0000},
    {1'b0, 32'h0100_0000, 16'h4000},
    {1'b0, 32'h1234_5678, 16'h1357},
    {1'b0, 32'hF000_0000, 16'hC000},
    {1'b0, 32'h8000_0001, 16'hFFFF},
    {1'b1, 32'h0003_3333, 16'h0000},
    {1'b1, 32'h4000_0000, 16'h2000},
    {1'b1, 32'hDEAD_BEEF, 16'hBEEF}
  };

  int n_chk = 0, n_bad = 0;
  int kidx, cnt_diff, cnt_up_a, cnt_up_b;
  logic [31:0] f_a, f_b;
  logic [15:0] o_a, o_b;
  bit d_a, d_b, have_last;
  string cur_tag;
  logic signed [15:0] l_as, l_ac, l_bs, l_bc;

  function automatic int expv(int a);
    real m;
    a = a & 4095;
    m = 32767.0 * $sin(6.283185307179586 * (real'(a) + 0.5) / 4096.0);
    if (m >= 0.0) return $rtoi(m + 0.5);
    return -$rtoi(-m + 0.5);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ch(int s, int c, logic [31:0] f, logic [15:0] o, bit d,
                        string ch, output bit up);
    logic [31:0] ph;
    int a;
    bit m0, m1;
    ph = f * kidx + {o, 16'h0000};
    a  = int'(ph[31:20]);
    m0 = (s == expv(a)) && (c == expv(a + 1024));
    m1 = (s == expv(a + 1)) && (c == expv(a + 1025));
    up = m1 && !m0;
    if (d) begin
      chk(m0 || m1, {cur_tag, " R6 dithered pair ", ch}, s, expv(a));
    end else begin
      chk(s == expv(a), {cur_tag, " R4 sine ", ch}, s, expv(a));
      chk(c == expv(a + 1024), {cur_tag, " R4 cosine ", ch}, c, expv(a + 1024));
    end
  endtask

  task automatic observe();
    bit ua, ub;
    if (out_vld) begin
      chk_ch(int'(a_sin), int'(a_cos), f_a, o_a, d_a, "chA", ua);
      chk_ch(int'(b_sin), int'(b_cos), f_b, o_b, d_b, "chB", ub);
      if (ua) cnt_up_a++;
      if (ub) cnt_up_b++;
      if (a_sin != b_sin) cnt_diff++;
      kidx++;
      l_as = a_sin; l_ac = a_cos; l_bs = b_sin; l_bc = b_cos;
      have_last = 1'b1;
    end else if (have_last) begin
      chk(a_sin == l_as && a_cos == l_ac && b_sin == l_bs && b_cos == l_bc,
          "R2 outputs hold while idle", int'(a_sin), int'(l_as));
    end
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      observe();
      samp_en = (i < n) && (gap == 0 || (i % gap) != gap - 1);
    end
    samp_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; samp_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    kidx = 0; cnt_diff = 0; cnt_up_a = 0; cnt_up_b = 0; have_last = 1'b0;
  endtask

  task automatic wr(logic [2:0] addr, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all(bit with_ctrl);
    wr(REG_FREQ_A, f_a);
    wr(REG_OFS_A, {16'h0000, o_a});
    wr(REG_FREQ_B, f_b);
    wr(REG_OFS_B, {16'h0000, o_b});
    if (with_ctrl) wr(REG_DITHER, {30'd0, d_b, d_a});
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; samp_en = 1'b0; wr_addr = '0; wr_data = '0;

    // R11: reset state
    do_reset();
    @(negedge clk);
    chk(out_vld == 1'b0, "R11 out_vld after reset", int'(out_vld), 0);
    chk(a_sin == 0 && a_cos == 0, "R11 channel A cleared", int'(a_sin), 0);
    chk(b_sin == 0 && b_cos == 0, "R11 channel B cleared", int'(b_sin), 0);

    // Vector table: R1 R3 R4 with dither off, R6 with dither on, R10 map
    for (int v = 0; v < 8; v++) begin
      d_a = VECS[v][48]; d_b = VECS[v][48];
      f_a = VECS[v][47:16]; o_a = VECS[v][15:0];
      f_b = -f_a; o_b = o_a ^ 16'h8000;
      cur_tag = $sformatf("vec%0d R1 R3 R10", v);
      do_reset();
      load_all(1'b1);
      run(20, 0);
    end

    // R8 latency with R5 full-scale codes
    cur_tag = "latency";
    do_reset();
    f_a = 0; o_a = 16'h4000; f_b = 0; o_b = 16'hC000; d_a = 0; d_b = 0;
    load_all(1'b1);
    @(negedge clk); samp_en = 1'b1;
    @(negedge clk); samp_en = 1'b0;
    chk(out_vld == 1'b0, "R8 not valid after one edge", int'(out_vld), 0);
    @(negedge clk);
    chk(out_vld == 1'b0, "R8 not valid after two edges", int'(out_vld), 0);
    @(negedge clk);
    chk(out_vld == 1'b1, "R8 valid after three edges", int'(out_vld), 1);
    chk(a_sin == 16'sh7FFF, "R5 positive full scale at quarter cycle", int'(a_sin), 32767);
    chk(int'(b_sin) == -32767, "R5 negative full scale 0x8001", int'(b_sin), -32767);
    chk(int'(a_cos) == expv(2048), "R4 cosine at half cycle", int'(a_cos), expv(2048));
    @(negedge clk);
    chk(out_vld == 1'b0, "R8 single-cycle valid", int'(out_vld), 0);

    // R2 strobe gaps: phase continues from where it stopped
    cur_tag = "gaps R2";
    do_reset();
    f_a = 32'h0765_4321; o_a = 16'h0123; f_b = 32'h2000_0000; o_b = 16'h0000;
    d_a = 0; d_b = 0;
    load_all(1'b1);
    run(30, 3);

    // R7 default dither on, R9 channels decorrelated
    cur_tag = "default dither";
    do_reset();
    f_a = 0; f_b = 0; o_a = 16'h000F; o_b = 16'h000F; d_a = 1; d_b = 1;
    load_all(1'b0);
    run(64, 0);
    chk(cnt_up_a > 0, "R7 channel A dither active after reset", cnt_up_a, 1);
    chk(cnt_up_b > 0, "R7 channel B dither active after reset", cnt_up_b, 1);
    chk(cnt_diff > 0, "R9 channel dither sequences differ", cnt_diff, 1);

    // R7 per-channel enable, R10 isolation
    cur_tag = "per-channel R10";
    do_reset();
    d_a = 0; d_b = 1;
    load_all(1'b1);
    run(64, 0);
    chk(cnt_up_a == 0, "R10 channel A unaffected by channel B dither", cnt_up_a, 0);
    chk(cnt_up_b > 0, "R7 channel B dither kept when A disabled", cnt_up_b, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule